// File: doc/BRIEF.md
# Accelerometer Threshold Interrupt Generator

This block watches a stream of three-axis acceleration samples. Each sample arrives with a one-cycle valid strobe. For every axis it forms a magnitude and compares it against a programmable 7-bit threshold. The result is a high event (above the threshold) and a low event (at or below it) per axis. A configuration byte selects which of the six events take part and how they combine: any of them, or all of them. The combined condition must then hold for a programmable number of consecutive samples before it counts.

A qualified condition raises the interrupt-active bit and the interrupt output, and the contributing events are recorded in a source register. There are two modes, chosen by a latch-enable input:

- In live mode, the source register simply mirrors the most recent sample.
- In latched mode, the source register freezes on the first qualified sample. It clears and re-arms only when it is read through the small register port.

The orientation-enable bit of the configuration is not interpreted here. It is passed out on a port of its own.

Top module: `accel_event_irq`

## Requirements
- R1: After reset the configuration, threshold, duration and source registers all read 0x00 and `irqOut` is low.
- R2: Register addresses are: 0 configuration, 1 threshold, 2 duration, 3 source. The configuration register stores all 8 written bits. The threshold and duration registers store bits 6:0, and their bit 7 always reads 0. Writes to address 3 are ignored.
- R3: An axis sample is signed two's complement, 12 bits wide. Its magnitude is the absolute value, saturated to 2047. The level is magnitude bits 10:4. The high event is level > threshold, and the low event is level <= threshold.
- R4: Configuration bit positions are: bit 7 all-mode, bit 6 orientation enable, bit 5 Z high, bit 4 Z low, bit 3 Y high, bit 2 Y low, bit 1 X high, bit 0 X low. With bit 7 = 0 the condition is the OR of the enabled events. With bit 7 = 1 it is the AND of the enabled events, and it is false when no event is enabled. Bit 6 has no effect on the combination and is driven on `orientEn`.
- R5: A sample qualifies when the condition holds on it and on the previous D consecutive samples, where D is the duration value. A duration of 0 qualifies on the first sample. A sample without the condition restarts the count, and cycles without a strobe neither advance nor reset it.
- R6: With `latchEn` low, every strobed sample rewrites the source register. A qualified sample writes IA = 1 with its enabled-event flags; any other sample writes 0x00. Reads have no effect in this mode.
- R7: Source register layout: bit 6 is IA, bit 5 ZH, bit 4 ZL, bit 3 YH, bit 2 YL, bit 1 XH, bit 0 XL, and bit 7 is 0. With `latchEn` high, the first qualified sample sets IA and the flags. The register then stays frozen until it is read.
- R8: With `latchEn` high, a read of address 3 (`regRdEn` high) returns the source value and then clears it. The next qualified sample sets it again.
- R9: With `latchEn` high, a source read in the same cycle as a qualified sample leaves the new sample's IA and flags in the register, not zero.
- R10: `irqOut` equals the IA bit. It changes at the clock edge that takes in the strobed sample or the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| latchEn | input | 1 | Selects latched source mode |
| sampleValid | input | 1 | One-cycle strobe marking a new sample |
| axisX | input | 12 | Signed X sample |
| axisY | input | 12 | Signed Y sample |
| axisZ | input | 12 | Signed Z sample |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears source in latched mode) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| irqOut | output | 1 | Interrupt output (IA) |
| orientEn | output | 1 | Configuration bit 6 passed through |

## Verification
A wrong duration count shows at `irqOut` on the first sample strobe where the count matters, one edge after that strobe. A qualification that comes one sample early or late is therefore caught within one sample period. A source register that fails to freeze, clear or re-arm shows up on the next read of address 3, or at `irqOut` after the next strobe. A magnitude or threshold comparison error shows as a wrong flag bit in the source value right after the edge that takes in the sample. The directed scenarios place samples just on each side of the threshold, including the most negative input, to expose it.

// File: rtl/accel_irq_pkg.sv
package accel_irq_pkg;
  localparam int NUM_AXES = 3;
  localparam int EV_W     = 2 * NUM_AXES;

  typedef enum logic [1:0] {
    ADDR_CFG = 2'd0,
    ADDR_THR = 2'd1,
    ADDR_DUR = 2'd2,
    ADDR_SRC = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic capture;    // a sample strobe is present this cycle
    logic qualified;  // this sample meets condition and duration
    logic clearSrc;   // source register is being read
  } ctlStrobes_t;
endpackage

// File: rtl/accel_irq_datapath.sv
module accel_irq_datapath
  import accel_irq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FIELD_W  = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       latchEn,
  input  logic signed [SAMPLE_W-1:0] axisX,
  input  logic signed [SAMPLE_W-1:0] axisY,
  input  logic signed [SAMPLE_W-1:0] axisZ,
  input  logic                       regWrEn,
  input  logic [1:0]                 regAddr,
  input  logic [FIELD_W:0]           regWrData,
  input  ctlStrobes_t                ctl,
  output logic [FIELD_W:0]           regRdData,
  output logic                       cond,
  output logic [FIELD_W-1:0]         durVal,
  output logic                       irqOut,
  output logic                       orientEn
);
  localparam int REG_W = FIELD_W + 1;
  localparam int MAG_W = SAMPLE_W - 1;
  localparam int IA_B  = EV_W;

  logic [REG_W-1:0]   cfgReg;
  logic [FIELD_W-1:0] thrReg;
  logic [FIELD_W-1:0] durReg;
  logic [EV_W:0]      srcReg;
  logic [EV_W-1:0]    events;
  logic [EV_W-1:0]    enabledEv;
  logic [EV_W-1:0]    evMask;
  logic               orHit;
  logic               andHit;

  logic signed [SAMPLE_W-1:0] axisArr [NUM_AXES];
  assign axisArr[0] = axisX;
  assign axisArr[1] = axisY;
  assign axisArr[2] = axisZ;

  for (genvar a = 0; a < NUM_AXES; a++) begin : gAxis
    logic [SAMPLE_W-1:0] negV;
    logic [SAMPLE_W-1:0] magFull;
    logic [MAG_W-1:0]    magSat;
    logic [FIELD_W-1:0]  level;
    assign negV    = -axisArr[a];
    assign magFull = axisArr[a][SAMPLE_W-1] ? negV : axisArr[a];
    assign magSat  = magFull[SAMPLE_W-1] ? {MAG_W{1'b1}} : magFull[MAG_W-1:0];
    assign level   = magSat[MAG_W-1 -: FIELD_W];
    assign events[2*a]   = (level <= thrReg);
    assign events[2*a+1] = (level >  thrReg);
  end

  assign evMask    = cfgReg[EV_W-1:0];
  assign enabledEv = events & evMask;
  assign orHit     = |enabledEv;
  assign andHit    = (enabledEv == evMask) && (|evMask);
  assign cond      = cfgReg[REG_W-1] ? andHit : orHit;
  assign durVal    = durReg;
  assign orientEn  = cfgReg[REG_W-2];
  assign irqOut    = srcReg[IA_B];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
      thrReg <= '0;
      durReg <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_CFG: cfgReg <= regWrData;
        ADDR_THR: thrReg <= regWrData[FIELD_W-1:0];
        ADDR_DUR: durReg <= regWrData[FIELD_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg <= '0;
    end else if (!latchEn) begin
      if (ctl.capture) srcReg <= ctl.qualified ? {1'b1, enabledEv} : '0;
    end else begin
      if (ctl.capture && ctl.qualified && (ctl.clearSrc || !srcReg[IA_B]))
        srcReg <= {1'b1, enabledEv};
      else if (ctl.clearSrc)
        srcReg <= '0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CFG: regRdData = cfgReg;
      ADDR_THR: regRdData = {1'b0, thrReg};
      ADDR_DUR: regRdData = {1'b0, durReg};
      default:  regRdData = {{(REG_W-EV_W-1){1'b0}}, srcReg};
    endcase
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_THR || regAddr == ADDR_DUR) |-> !regRdData[REG_W-1]);
  assert_live_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEn && ctl.capture) |=> (irqOut == $past(ctl.qualified)));
  assert_latched_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && irqOut && !ctl.clearSrc) |=> $stable(srcReg));
  assert_no_flags_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (srcReg == '0));
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && ctl.clearSrc && !(ctl.capture && ctl.qualified)) |=> !irqOut);
  assert_new_event_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && ctl.clearSrc && ctl.capture && ctl.qualified) |=> irqOut);
endmodule

// File: rtl/accel_irq_ctrl.sv
module accel_irq_ctrl
  import accel_irq_pkg::*;
#(
  parameter int FIELD_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic               cond,
  input  logic [FIELD_W-1:0] durVal,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  output ctlStrobes_t        ctl
);
  logic [FIELD_W-1:0] runCnt;

  assign ctl.capture   = sampleValid;
  assign ctl.qualified = sampleValid && cond && (runCnt >= durVal);
  assign ctl.clearSrc  = regRdEn && (regAddr == ADDR_SRC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (sampleValid) begin
      if (!cond)                runCnt <= '0;
      else if (runCnt < durVal) runCnt <= runCnt + 1'b1;
    end
  end

  assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !cond) |=> (runCnt == '0));
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && cond && (runCnt < durVal)) |=> (runCnt == $past(runCnt) + 1'b1));
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(runCnt));
endmodule

// File: rtl/accel_event_irq.sv
module accel_event_irq
  import accel_irq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FIELD_W  = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       latchEn,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] axisX,
  input  logic signed [SAMPLE_W-1:0] axisY,
  input  logic signed [SAMPLE_W-1:0] axisZ,
  input  logic                       regWrEn,
  input  logic                       regRdEn,
  input  logic [1:0]                 regAddr,
  input  logic [FIELD_W:0]           regWrData,
  output logic [FIELD_W:0]           regRdData,
  output logic                       irqOut,
  output logic                       orientEn
);
  ctlStrobes_t        ctl;
  logic               cond;
  logic [FIELD_W-1:0] durVal;

  accel_irq_ctrl #(.FIELD_W(FIELD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .cond(cond),
    .durVal(durVal), .regRdEn(regRdEn), .regAddr(regAddr), .ctl(ctl)
  );

  accel_irq_datapath #(.SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W)) dp_i (
    .clk(clk), .rstN(rstN), .latchEn(latchEn),
    .axisX(axisX), .axisY(axisY), .axisZ(axisZ),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .ctl(ctl),
    .regRdData(regRdData), .cond(cond), .durVal(durVal),
    .irqOut(irqOut), .orientEn(orientEn)
  );
endmodule

// File: tb/accel_event_irq_tb.sv
module accel_event_irq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchEn = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [11:0] axisX = '0, axisY = '0, axisZ = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqOut, orientEn;
  int nChecks = 0;
  int nFails = 0;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  accel_event_irq dut_i (
    .clk(clk), .rstN(rstN), .latchEn(latchEn), .sampleValid(sampleValid),
    .axisX(axisX), .axisY(axisY), .axisZ(axisZ),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .orientEn(orientEn)
  );

  task automatic check(input int actual, input int expected, input string tag);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Reads with the strobe; the value is taken before the clearing edge.
  task automatic rdReg(input logic [1:0] a, output int v);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 v = int'(regRdData);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic peekSrc(output int v);
    regAddr = 2'd3;
    #1 v = int'(regRdData);
  endtask

  task automatic sendSample(input int x, input int y, input int z);
    @(negedge clk);
    axisX = 12'(x); axisY = 12'(y); axisZ = 12'(z); sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic testReset();
    int v;
    doReset();
    for (int a = 0; a < 4; a++) begin
      rdReg(2'(a), v);
      check(v, 0, "R1 register reset value");
    end
    check(int'(irqOut), 0, "R1 irq after reset");
  endtask

  task automatic testRegisters();
    int v;
    doReset();
    wrReg(2'd0, 8'hA5); rdReg(2'd0, v); check(v, 'hA5, "R2 configuration readback");
    wrReg(2'd1, 8'hFF); rdReg(2'd1, v); check(v, 'h7F, "R2 threshold bit 7 reads 0");
    wrReg(2'd2, 8'h83); rdReg(2'd2, v); check(v, 'h03, "R2 duration bit 7 reads 0");
    wrReg(2'd3, 8'hFF); peekSrc(v);     check(v, 'h00, "R2 source write ignored");
    check(int'(orientEn), 0, "R4 orientation bit clear in 0xA5");
  endtask

  task automatic testLive();
    int v;
    doReset();
    latchEn = 1'b0;
    wrReg(2'd1, 8'd16);
    wrReg(2'd0, 8'h02);
    @(negedge clk);
    axisX = 12'sd400; axisY = '0; axisZ = '0; sampleValid = 1'b1;
    #1 check(int'(irqOut), 0, "R10 irq unchanged before edge");
    @(negedge clk);
    sampleValid = 1'b0;
    check(int'(irqOut), 1, "R10 irq after edge");
    peekSrc(v); check(v, 'h42, "R3 X high flag with IA");
    rdReg(2'd3, v); check(v, 'h42, "R6 source value live");
    check(int'(irqOut), 1, "R6 read has no effect in live mode");
    sendSample(100, 0, 0);
    peekSrc(v); check(v, 'h00, "R6 source drops with live condition");
    sendSample(-400, 0, 0);
    check(int'(irqOut), 1, "R3 negative sample magnitude");
    sendSample(271, 0, 0);
    check(int'(irqOut), 0, "R3 level equal to threshold is not high");
    wrReg(2'd1, 8'd126);
    sendSample(-2048, 0, 0);
    check(int'(irqOut), 1, "R3 saturated most negative sample");
  endtask

  task automatic testCombine();
    int v;
    doReset();
    latchEn = 1'b0;
    wrReg(2'd1, 8'd16);
    wrReg(2'd0, 8'h8A);
    sendSample(400, 100, 0);
    check(int'(irqOut), 0, "R4 AND with one event missing");
    sendSample(400, 400, 0);
    peekSrc(v); check(v, 'h4A, "R4 AND with all events");
    wrReg(2'd0, 8'h0A);
    sendSample(400, 100, 0);
    peekSrc(v); check(v, 'h42, "R4 OR with one event");
    wrReg(2'd0, 8'h80);
    sendSample(400, 400, 400);
    check(int'(irqOut), 0, "R4 AND with nothing enabled");
    wrReg(2'd0, 8'h4A);
    sendSample(400, 100, 0);
    check(int'(irqOut), 1, "R4 orientation bit acts as OR");
    check(int'(orientEn), 1, "R4 orientation passthrough");
  endtask

  task automatic testDuration();
    doReset();
    latchEn = 1'b0;
    wrReg(2'd1, 8'd16);
    wrReg(2'd0, 8'h02);
    wrReg(2'd2, 8'd2);
    sendSample(400, 0, 0);
    check(int'(irqOut), 0, "R5 first sample not enough");
    repeat (10) @(negedge clk);
    sendSample(400, 0, 0);
    check(int'(irqOut), 0, "R5 idle cycles do not count");
    sendSample(400, 0, 0);
    check(int'(irqOut), 1, "R5 qualifies after duration");
    sendSample(100, 0, 0);
    sendSample(400, 0, 0);
    sendSample(400, 0, 0);
    check(int'(irqOut), 0, "R5 drop restarts count");
    sendSample(400, 0, 0);
    check(int'(irqOut), 1, "R5 qualifies again after restart");
  endtask

  task automatic testLatched();
    int v;
    doReset();
    latchEn = 1'b1;
    wrReg(2'd1, 8'd16);
    wrReg(2'd0, 8'h03);
    sendSample(400, 0, 0);
    peekSrc(v); check(v, 'h42, "R7 latched set");
    sendSample(100, 0, 0);
    peekSrc(v); check(v, 'h42, "R7 latched frozen");
    rdReg(2'd3, v); check(v, 'h42, "R8 read returns latched value");
    check(int'(irqOut), 0, "R8 read clears irq");
    peekSrc(v); check(v, 'h00, "R8 source cleared");
    sendSample(100, 0, 0);
    peekSrc(v); check(v, 'h41, "R8 re-armed after read");
    @(negedge clk);
    axisX = 12'sd400; sampleValid = 1'b1; regAddr = 2'd3; regRdEn = 1'b1;
    #1 v = int'(regRdData);
    @(negedge clk);
    sampleValid = 1'b0; regRdEn = 1'b0;
    check(v, 'h41, "R9 coincident read returns old value");
    check(int'(irqOut), 1, "R9 new event wins over read");
    peekSrc(v); check(v, 'h42, "R9 new flags kept");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testRegisters();
    testLive();
    testCombine();
    testDuration();
    testLatched();
    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule